// File: doc/BRIEF.md
# Multi-Channel Control Register Bank with Broadcast Write

This block keeps eight identical copies of a small byte-wide control register set, one copy per framer channel. A single synchronous processor bus reaches all of them. The upper four bits of the 12-bit address carry a channel code, and the lower eight bits pick a register inside the channel. Code 8 is reserved. A write with code 8 lands in the same register of every channel in one clock. Each channel's full register set is driven out in parallel to the logic that consumes it.

A small bus-control state machine sequences the bank. `ST_IDLE` waits for a strobe. `ST_RDATA` presents registered read data for exactly one cycle per accepted read. `ST_CLEAR` is held while the software reset is applied and for one cycle after it.

The machine has these transitions:
- IDLE→RDATA and RDATA→RDATA on an accepted read.
- IDLE→IDLE and RDATA→IDLE when no read is accepted.
- Any state→CLEAR while `sw_rst` is high.
- CLEAR→IDLE once `sw_rst` is low.

The bank has three ways to restore the reset values:
- The asynchronous `rst_n` pin.
- The synchronous `sw_rst` input.
- A self-acting reset bit inside each channel's register 0.

Top module: `rbank_top`

## Requirements
- R1: A write whose channel code (addr[11:8]) is 0 to 7 updates only the addressed register of that channel. A read with such a code returns that channel's register byte in rdata[7:0] on the cycle after rd_en, with rd_valid high.
- R2: A write with channel code 8 updates the addressed register of all eight channels at the same clock edge.
- R3: A read with channel code 8 returns channel 0's register byte.
- R4: A write with channel code 9 to 15 changes no register. A read with such a code returns rdata = 0 with rd_valid high.
- R5: Only wdata[7:0] is stored, and wdata[15:8] has no effect. rdata[15:8] always reads 0.
- R6: After rst_n is asserted, register r of every channel holds the byte {r[3:0], ~r[3:0]}. The exception is bits 7:4 of register 7, which keep no defined reset value.
- R7: A cycle with sw_rst high restores the R6 values in all channels. The state machine then stays in ST_CLEAR for the cycle after sw_rst falls. Writes and reads are ignored while sw_rst is high and during that cycle, and no rd_valid follows them.
- R8: A write of a byte with bit 7 set to register 0 stores nothing and restores the R6 values in every register of the addressed channel, or of all channels for code 8. Register 0 then reads 0x0F.
- R9: A register offset (addr[7:0]) of 8 or more is ignored on writes and reads back as 0.
- R10: rd_valid is high only on the cycle after an accepted read, and rdata is 0 whenever rd_valid is low. A read accepted in the same cycle as a write to the same register returns the value from before the write.
- R11: ch_regs carries register r of channel c on bits [(c*8+r)*8 +: 8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset for all channels |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| addr | input | 12 | Channel code [11:8], register offset [7:0] |
| wdata | input | 16 | Write data; only the low byte is stored |
| rdata | output | 16 | Registered read data, zero when not valid |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| ch_regs | output | 512 | All registers of all channels, flattened |

## Verification
The assertions assume that the strobes, address and data are stable around each rising edge. They also assume that a read or write presented while sw_rst is high, or in the cycle after it, is meant to be dropped rather than retried. The bench drives every input on the falling edge and holds each strobe for exactly one cycle. It deliberately places one write inside the clear window, in the cycle after sw_rst falls. The only case where both strobes are asserted together is the same-register read-during-write scenario.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int REG_W  = 8;
    localparam int CODE_W = 4;
    localparam int CH_RST_BIT = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RDATA = 2'd1,
        ST_CLEAR = 2'd2
    } bus_state_t;

    // Reset byte of register r: its index in the high nibble, inverted index low.
    function automatic logic [REG_W-1:0] reset_byte(input int r);
        logic [3:0] n;
        n = r[3:0];
        return {n, ~n};
    endfunction

    // Bits that receive no reset: the high nibble of the last register.
    function automatic logic [REG_W-1:0] undef_mask(input int r, input int nregs);
        return (r == nregs - 1) ? 8'hF0 : 8'h00;
    endfunction

endpackage

// File: rtl/rbank_decode.sv
module rbank_decode
    import rbank_pkg::*;
#(
    parameter int CH_N   = 8,
    parameter int REG_N  = 8,
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3,
    parameter int SEL_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_go,
    output logic [CH_N-1:0]   ch_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [SEL_W-1:0]  rd_sel,
    output logic              rd_hit
);

    localparam int OFS_W = ADDR_W - CODE_W;

    logic [CODE_W-1:0] code;
    logic [OFS_W-1:0]  ofs;
    logic              ofs_ok;
    logic              bcast;

    assign code    = addr[ADDR_W-1 -: CODE_W];
    assign ofs     = addr[OFS_W-1:0];
    assign ofs_ok  = (ofs < OFS_W'(REG_N));
    assign bcast   = (code == CODE_W'(CH_N));
    assign reg_idx = ofs[IDX_W-1:0];

    generate
        for (genvar c = 0; c < CH_N; c++) begin : g_we
            assign ch_we[c] = wr_go && ofs_ok && (bcast || (code == CODE_W'(c)));
        end
    endgenerate

    always_comb begin
        rd_sel = bcast ? '0 : code[SEL_W-1:0];
        rd_hit = ofs_ok && (code <= CODE_W'(CH_N));
    end

endmodule

// File: rtl/rbank_channel.sv
module rbank_channel
    import rbank_pkg::*;
#(
    parameter int REG_N = 8,
    parameter int IDX_W = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   we,
    input  logic [IDX_W-1:0]       reg_idx,
    input  logic [REG_W-1:0]       wbyte,
    output logic [REG_N*REG_W-1:0] regs
);

    logic ch_rst;

    assign ch_rst = we && (reg_idx == '0) && wbyte[CH_RST_BIT];

    generate
        for (genvar r = 0; r < REG_N; r++) begin : g_reg
            localparam logic [REG_W-1:0] RV = reset_byte(r);
            localparam logic [REG_W-1:0] UM = undef_mask(r, REG_N);

            logic             hit;
            logic [REG_W-1:0] rq;
            logic [REG_W-1:0] uq;

            assign hit = we && (reg_idx == IDX_W'(r));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rq <= RV;
                end else if (clear || ch_rst) begin
                    rq <= RV;
                end else if (hit) begin
                    rq <= wbyte;
                end
            end

            always_ff @(posedge clk) begin
                if (hit && !ch_rst) begin
                    uq <= wbyte;
                end
            end

            assign regs[r*REG_W +: REG_W] = (rq & ~UM) | (uq & UM);
        end
    endgenerate

endmodule

// File: rtl/rbank_rdmux.sv
module rbank_rdmux
    import rbank_pkg::*;
#(
    parameter int CH_N  = 8,
    parameter int REG_N = 8,
    parameter int IDX_W = 3,
    parameter int SEL_W = 3
) (
    input  logic [CH_N*REG_N*REG_W-1:0] regs_all,
    input  logic [SEL_W-1:0]            rd_sel,
    input  logic [IDX_W-1:0]            reg_idx,
    input  logic                        rd_hit,
    output logic [REG_W-1:0]            rbyte
);

    always_comb begin
        int base;
        base  = (int'(rd_sel) * REG_N + int'(reg_idx)) * REG_W;
        rbyte = '0;
        if (rd_hit) begin
            rbyte = regs_all[base +: REG_W];
        end
    end

endmodule

// File: rtl/rbank_top.sv
module rbank_top
    import rbank_pkg::*;
#(
    parameter int CH_N   = 8,
    parameter int REG_N  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sw_rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    output logic                        rd_valid,
    output logic [CH_N*REG_N*REG_W-1:0] ch_regs
);

    localparam int IDX_W  = $clog2(REG_N);
    localparam int SEL_W  = $clog2(CH_N);
    localparam int BANK_W = REG_N * REG_W;

    bus_state_t       state, state_nx;
    logic             in_clear;
    logic             bus_ok;
    logic             wr_go;
    logic             rd_go;
    logic [CH_N-1:0]  ch_we;
    logic [IDX_W-1:0] reg_idx;
    logic [SEL_W-1:0] rd_sel;
    logic             rd_hit;
    logic [REG_W-1:0] rbyte;
    logic [REG_W-1:0] rd_q;

    assign in_clear = (state == ST_CLEAR);
    assign bus_ok   = !sw_rst && !in_clear;
    assign wr_go    = wr_en && bus_ok;
    assign rd_go    = rd_en && bus_ok;

    rbank_decode #(
        .CH_N(CH_N), .REG_N(REG_N), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_decode (
        .addr(addr), .wr_go(wr_go), .ch_we(ch_we),
        .reg_idx(reg_idx), .rd_sel(rd_sel), .rd_hit(rd_hit)
    );

    generate
        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            rbank_channel #(.REG_N(REG_N), .IDX_W(IDX_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .clear(sw_rst), .we(ch_we[c]),
                .reg_idx(reg_idx), .wbyte(wdata[REG_W-1:0]),
                .regs(ch_regs[c*BANK_W +: BANK_W])
            );
        end
    endgenerate

    rbank_rdmux #(
        .CH_N(CH_N), .REG_N(REG_N), .IDX_W(IDX_W), .SEL_W(SEL_W)
    ) u_rdmux (
        .regs_all(ch_regs), .rd_sel(rd_sel), .reg_idx(reg_idx),
        .rd_hit(rd_hit), .rbyte(rbyte)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_RDATA: begin
                if (sw_rst) begin
                    state_nx = ST_CLEAR;
                end else if (rd_go) begin
                    state_nx = ST_RDATA;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_CLEAR: begin
                state_nx = sw_rst ? ST_CLEAR : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_go) begin
            rd_q <= rbyte;
        end
    end

    // Outputs
    always_comb begin
        rd_valid = 1'b0;
        rdata    = '0;
        unique case (state)
            ST_RDATA: begin
                rd_valid = 1'b1;
                rdata    = {{(DATA_W-REG_W){1'b0}}, rd_q};
            end
            ST_IDLE, ST_CLEAR: begin
                rd_valid = 1'b0;
            end
            default: rd_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/rbank_chk.sv
module rbank_chk
    import rbank_pkg::*;
#(
    parameter int CH_N   = 8,
    parameter int REG_N  = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        sw_rst,
    input logic                        rd_en,
    input logic                        rd_valid,
    input logic                        in_clear,
    input logic [CODE_W-1:0]           code,
    input logic [DATA_W-1:0]           wdata,
    input logic [CH_N-1:0]             ch_we,
    input logic [IDX_W-1:0]            reg_idx,
    input logic [CH_N*REG_N*REG_W-1:0] ch_regs
);

    logic [DATA_W-1:0] wd_lo;
    assign wd_lo = wdata & {{(DATA_W-REG_W){1'b0}}, {REG_W{1'b1}}};

    AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !sw_rst && !in_clear) |=> rd_valid); // R10

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !sw_rst && !in_clear) |=> !rd_valid); // R10

    AST_WE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_we) || (&ch_we)); // R1

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((code == CODE_W'(CH_N)) && (ch_we != '0)) |-> (&ch_we)); // R2

    AST_BAD_CODE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (code > CODE_W'(CH_N)) |-> (ch_we == '0)); // R4

    AST_LOW_BYTE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_we[0] && (reg_idx == IDX_W'(1)))
        |=> (DATA_W'(ch_regs[2*REG_W-1:REG_W]) == $past(wd_lo))); // R5

    AST_SWRST_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (ch_regs[REG_W-1:0] == reset_byte(0))); // R7

    AST_CLEAR_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        in_clear |=> $stable(ch_regs)); // R7

endmodule

bind rbank_top rbank_chk #(
    .CH_N(CH_N), .REG_N(REG_N), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .rd_en(rd_en),
    .rd_valid(rd_valid), .in_clear(in_clear),
    .code(addr[ADDR_W-1 -: 4]), .wdata(wdata), .ch_we(ch_we),
    .reg_idx(reg_idx), .ch_regs(ch_regs)
);

// File: tb/rbank_top_test.sv
`timescale 1ns/1ps
module rbank_top_test;

    logic         clk = 1'b0;
    logic         rst_n, sw_rst, wr_en, rd_en;
    logic [11:0]  addr;
    logic [15:0]  wdata;
    logic [15:0]  rdata;
    logic         rd_valid;
    logic [511:0] ch_regs;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m [8][8];

    always #2 clk = ~clk;

    rbank_top uut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .ch_regs(ch_regs)
    );

    function automatic logic [7:0] rv(input int r);
        logic [3:0] n;
        n = r[3:0];
        return {n, ~n};
    endfunction

    function automatic logic [7:0] care(input int r);
        return (r == 7) ? 8'h0F : 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset_ch(input int c);
        for (int r = 0; r < 8; r++) m[c][r] = rv(r);
    endtask

    task automatic model_reset_all();
        for (int c = 0; c < 8; c++) model_reset_ch(c);
    endtask

    task automatic cmp_all(input string req);
        logic [7:0] a, e;
        bit bad;
        bad = 0;
        checks++;
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 8; r++) begin
                a = ch_regs[(c*8+r)*8 +: 8] & care(r);
                e = m[c][r] & care(r);
                if (a !== e && !bad) begin
                    bad = 1;
                    errors++;
                    $display("FAIL %s ch%0d reg%0d actual %h expected %h", req, c, r, a, e);
                end
            end
        end
    endtask

    task automatic bus_wr(input logic [3:0] code, input logic [7:0] ofs, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = {code, ofs}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 16'h0;
    endtask

    task automatic bus_rd(input logic [3:0] code, input logic [7:0] ofs,
                          output logic [15:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; addr = {code, ofs};
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata; v = rd_valid;
    endtask

    task automatic t_reset();
        logic [15:0] d; logic v;
        chk("R10 idle rd_valid after reset", {31'b0, rd_valid}, 32'd0);
        chk("R10 idle rdata after reset", {16'b0, rdata}, 32'd0);
        cmp_all("R6 reset values");
        bus_rd(4'd5, 8'd3, d, v);
        chk("R6 read reset ch5 reg3", {15'b0, v, d}, {15'b0, 1'b1, 16'h003C});
        @(negedge clk);
        chk("R10 valid lasts one cycle", {31'b0, rd_valid}, 32'd0);
        chk("R10 rdata zero when not valid", {16'b0, rdata}, 32'd0);
    endtask

    task automatic t_single();
        logic [15:0] d; logic v;
        bus_wr(4'd3, 8'd2, 16'hFFA5);
        m[3][2] = 8'hA5;
        cmp_all("R1 R11 single-channel write layout");
        bus_rd(4'd3, 8'd2, d, v);
        chk("R1 read back ch3 reg2", {15'b0, v, d}, {15'b0, 1'b1, 16'h00A5});
        chk("R5 upper read bits zero", {24'b0, d[15:8]}, 32'd0);
        bus_rd(4'd2, 8'd2, d, v);
        chk("R1 neighbour channel untouched", {16'b0, d}, 32'h002D);
        bus_wr(4'd0, 8'd7, 16'h12E1);
        m[0][7] = 8'hE1;
        bus_rd(4'd0, 8'd7, d, v);
        chk("R5 R1 full byte of reg7", {16'b0, d}, 32'h00E1);
    endtask

    task automatic t_bcast();
        logic [15:0] d; logic v;
        bus_wr(4'd8, 8'd5, 16'h5AC3);
        for (int c = 0; c < 8; c++) m[c][5] = 8'hC3;
        cmp_all("R2 broadcast reaches all channels");
        bus_rd(4'd7, 8'd5, d, v);
        chk("R2 broadcast read ch7", {16'b0, d}, 32'h00C3);
    endtask

    task automatic t_bcast_read();
        logic [15:0] d; logic v;
        bus_wr(4'd0, 8'd1, 16'h0011);
        bus_wr(4'd1, 8'd1, 16'h0022);
        m[0][1] = 8'h11; m[1][1] = 8'h22;
        bus_rd(4'd8, 8'd1, d, v);
        chk("R3 code 8 read returns ch0", {15'b0, v, d}, {15'b0, 1'b1, 16'h0011});
    endtask

    task automatic t_badcode();
        logic [15:0] d; logic v;
        bus_wr(4'd9, 8'd3, 16'h00EE);
        bus_wr(4'd15, 8'd3, 16'h00DD);
        cmp_all("R4 codes 9 and 15 write nothing");
        bus_rd(4'd12, 8'd3, d, v);
        chk("R4 code 12 read zero", {15'b0, v, d}, {15'b0, 1'b1, 16'h0000});
    endtask

    task automatic t_badofs();
        logic [15:0] d; logic v;
        bus_wr(4'd2, 8'h20, 16'h0077);
        bus_wr(4'd2, 8'h08, 16'h0066);
        cmp_all("R9 out-of-range offset write ignored");
        bus_rd(4'd2, 8'h08, d, v);
        chk("R9 out-of-range offset reads zero", {15'b0, v, d}, {15'b0, 1'b1, 16'h0000});
    endtask

    task automatic t_chrst();
        logic [15:0] d; logic v;
        bus_wr(4'd4, 8'd3, 16'h0099);
        bus_wr(4'd4, 8'd0, 16'h0005);
        bus_wr(4'd5, 8'd3, 16'h0044);
        m[4][3] = 8'h99; m[4][0] = 8'h05; m[5][3] = 8'h44;
        cmp_all("R8 setup");
        bus_wr(4'd4, 8'd0, 16'h0080);
        model_reset_ch(4);
        cmp_all("R8 channel reset bit restores ch4 only");
        bus_rd(4'd4, 8'd0, d, v);
        chk("R8 reg0 reads 0x0F", {16'b0, d}, 32'h000F);
        bus_wr(4'd8, 8'd0, 16'h00FF);
        model_reset_all();
        cmp_all("R8 broadcast channel reset");
    endtask

    task automatic t_swrst();
        logic [15:0] d; logic v;
        bus_wr(4'd1, 8'd2, 16'h00AB);
        bus_wr(4'd6, 8'd6, 16'h00CD);
        @(negedge clk);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        wr_en = 1'b1; addr = {4'd1, 8'd2}; wdata = 16'h0055;
        @(negedge clk);
        wr_en = 1'b0;
        model_reset_all();
        cmp_all("R7 sw reset restores and clear-cycle write ignored");
        @(negedge clk);
        sw_rst = 1'b1; rd_en = 1'b1; addr = {4'd0, 8'd0};
        @(negedge clk);
        sw_rst = 1'b0; rd_en = 1'b0;
        chk("R7 read during sw_rst gives no valid", {31'b0, rd_valid}, 32'd0);
        bus_wr(4'd1, 8'd2, 16'h0055);
        m[1][2] = 8'h55;
        bus_rd(4'd1, 8'd2, d, v);
        chk("R7 bus works after clear", {15'b0, v, d}, {15'b0, 1'b1, 16'h0055});
    endtask

    task automatic t_rw_same();
        logic [15:0] d; logic v;
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; addr = {4'd6, 8'd4}; wdata = 16'h0077;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 read-during-write old value", {15'b0, rd_valid, rdata}, {15'b0, 1'b1, 16'h004B});
        m[6][4] = 8'h77;
        bus_rd(4'd6, 8'd4, d, v);
        chk("R10 new value after write", {16'b0, d}, 32'h0077);
    endtask

    task automatic t_hwrst();
        bus_wr(4'd3, 8'd1, 16'h0001);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset_all();
        cmp_all("R6 hardware reset mid-run");
        chk("R6 rd_valid low after reset", {31'b0, rd_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; sw_rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        addr = '0; wdata = '0;
        model_reset_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_bcast();
        t_bcast_read();
        t_badcode();
        t_badofs();
        t_chrst();
        t_swrst();
        t_rw_same();
        t_hwrst();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule